// File: doc/BRIEF.md
# Masked Address CAM Array

This block is a storage and match core for 48-bit network addresses. It holds a set of entries, each made of a stored address, a per-bit mask that picks which bit positions are compared, and a 6-bit attribute field. One search request compares a key against every valid entry in the same cycle. The result (hit, index of the lowest matching entry, multiple-match flag, and the source and exact qualifiers of that entry) is registered and held until the next search.

The surrounding logic uses a simple request port. A write stores an address, mask and attributes into the lowest-numbered free entry. A single invalidate frees one entry by index, usually an index returned by an earlier search. Invalidate-all frees every entry at once. A per-entry exclusion bit hides an entry from host searches without freeing it, so a controller can step through duplicates. Searches from the receive path ignore the exclusion bit. A full flag shows that no free entry is left.

Attribute layout: bit 0 valid, bit 1 source (1) or destination (0), bit 2 exact, bit 3 exclude-from-host-search, bits 5:4 reserved. When several updates arrive in one cycle, invalidate-all wins over single invalidate. Single invalidate wins over write. A write wins over an exclusion update.

Top module: `addr_cam`

## Requirements
- R1: An entry matches only if the key equals the stored address at every bit position where that entry's mask bit is 1. Positions where the mask bit is 0 are don't-care.
- R2: Only entries whose valid bit (attribute bit 0) is set take part in a search, and all such entries are compared in the same search.
- R3: On a hit, `hit_idx` gives the lowest-numbered matching entry, and `hit_src`/`hit_exact` give attribute bits 1 and 2 of that entry. On a miss, `hit`, `hit_idx`, `multi`, `hit_src` and `hit_exact` are all 0.
- R4: `multi` is 1 when two or more entries match the search, and 0 otherwise.
- R5: An entry with attribute bit 3 set is skipped by searches with `srch_host`=1 but still matches searches with `srch_host`=0. `excl_req` sets or clears bit 3 of entry `excl_idx` to `excl_val` without changing its validity.
- R6: A write stores key, mask and attribute into the lowest-numbered invalid entry, with bit 0 forced to 1 and the other attribute bits stored as given.
- R7: `full` is 1 exactly when every entry is valid. A write while `full` is 1 is ignored and leaves the stored contents unchanged.
- R8: `inv_req` clears the valid bit of entry `inv_idx`. `inv_all` clears the valid bit of every entry in one cycle.
- R9: Search results appear on the outputs one clock after the cycle in which `srch_req` is sampled, and are held unchanged until the next search request.
- R10: After synchronous reset, every entry is invalid, `full` is 0, and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_req | input | 1 | Store a new entry |
| wr_key | input | 48 | Address to store |
| wr_mask | input | 48 | Compare mask to store, 1 = compared |
| wr_attr | input | 6 | Attribute field to store |
| inv_req | input | 1 | Invalidate one entry |
| inv_idx | input | 5 | Entry to invalidate |
| inv_all | input | 1 | Invalidate every entry |
| excl_req | input | 1 | Update an entry's exclusion bit |
| excl_idx | input | 5 | Entry whose exclusion bit is updated |
| excl_val | input | 1 | New exclusion bit value |
| srch_req | input | 1 | Start a search |
| srch_key | input | 48 | Search key |
| srch_host | input | 1 | 1 = host search (exclusions apply), 0 = receive-path search |
| hit | output | 1 | At least one entry matched |
| hit_idx | output | 5 | Lowest matching entry |
| multi | output | 1 | More than one entry matched |
| hit_src | output | 1 | Source bit of the reported entry |
| hit_exact | output | 1 | Exact bit of the reported entry |
| full | output | 1 | No invalid entry remains |

## Verification
The bench builds two entries with the same address but different masks. This shows whether the lowest index wins and whether `multi` rises. A design with a reversed priority order would report entry 1, and a design that treats a 0 mask bit as "compared" would miss the key with a different low byte. Exclusion is checked under both host and receive-path searches. A design that applies it to both paths, or that treats excluded entries as freed, gives the wrong index or a false hit. The bench fills the array to the last entry, then shows that an extra write is dropped and that a freed low slot is reused. A design with an off-by-one full flag, or one that overwrites an entry when full, gives a visible wrong result.

// File: rtl/addr_cam_pkg.sv
// Package: shared constants for the masked address CAM.
// Assumes attribute bit positions are fixed by the host-side contract.
package addr_cam_pkg;
    localparam int CAM_ENTRIES = 32;
    localparam int CAM_ADDR_W  = 48;
    localparam int CAM_ATTR_W  = 6;
    localparam int ATTR_VALID  = 0;
    localparam int ATTR_SRC    = 1;
    localparam int ATTR_EXACT  = 2;
    localparam int ATTR_EXCL   = 3;
endpackage

// File: rtl/addr_cam_entry.sv
// Module: one CAM entry. It holds the address, mask and attributes and
// produces a combinational match for the current search key.
// Assumes that at most one of clear/load/excl_we is active (the top gives them priority).
module addr_cam_entry
    import addr_cam_pkg::*;
#(
    parameter int ADDR_W = CAM_ADDR_W,
    parameter int ATTR_W = CAM_ATTR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load,
    input  logic              excl_we,
    input  logic              excl_val,
    input  logic [ADDR_W-1:0] wr_key,
    input  logic [ADDR_W-1:0] wr_mask,
    input  logic [ATTR_W-1:0] wr_attr,
    input  logic [ADDR_W-1:0] srch_key,
    input  logic              srch_host,
    output logic              valid,
    output logic              match,
    output logic              src,
    output logic              exact
);
    logic [ADDR_W-1:0] cmp_q;
    logic [ADDR_W-1:0] mask_q;
    logic [ATTR_W-1:0] attr_q;

    // Storage update: reset, invalidate, load or exclusion change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q  <= '0;
            mask_q <= '0;
            attr_q <= '0;
        end else if (clear) begin
            attr_q[ATTR_VALID] <= 1'b0;
        end else if (load) begin
            cmp_q  <= wr_key;
            mask_q <= wr_mask;
            attr_q <= wr_attr | ATTR_W'(1 << ATTR_VALID);
        end else if (excl_we) begin
            attr_q[ATTR_EXCL] <= excl_val;
        end
    end

    // Masked compare, gated by validity and host exclusion.
    always_comb begin
        match = attr_q[ATTR_VALID]
              && (((srch_key ^ cmp_q) & mask_q) == '0)
              && !(srch_host && attr_q[ATTR_EXCL]);
    end

    assign valid = attr_q[ATTR_VALID];
    assign src   = attr_q[ATTR_SRC];
    assign exact = attr_q[ATTR_EXACT];
endmodule

// File: rtl/addr_cam_first.sv
// Module: lowest-index finder. It returns whether any request bit is set
// and the index of the lowest set bit (0 when none is set).
module addr_cam_first #(
    parameter int N     = 32,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Scan downward so that the lowest set bit is written last and wins.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
        found = |req;
    end
endmodule

// File: rtl/addr_cam.sv
// Module: masked address CAM top. It arbitrates the update requests,
// picks the free slot for writes, and registers the search results.
// Assumes synchronous active-low reset. A search sees the contents as
// they were before any update in the same cycle.
module addr_cam
    import addr_cam_pkg::*;
#(
    parameter int ENTRIES = CAM_ENTRIES,
    parameter int ADDR_W  = CAM_ADDR_W,
    parameter int ATTR_W  = CAM_ATTR_W,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_key,
    input  logic [ADDR_W-1:0] wr_mask,
    input  logic [ATTR_W-1:0] wr_attr,
    input  logic              inv_req,
    input  logic [IDX_W-1:0]  inv_idx,
    input  logic              inv_all,
    input  logic              excl_req,
    input  logic [IDX_W-1:0]  excl_idx,
    input  logic              excl_val,
    input  logic              srch_req,
    input  logic [ADDR_W-1:0] srch_key,
    input  logic              srch_host,
    output logic              hit,
    output logic [IDX_W-1:0]  hit_idx,
    output logic              multi,
    output logic              hit_src,
    output logic              hit_exact,
    output logic              full
);
    logic [ENTRIES-1:0] valid_v, match_v, src_v, exact_v;
    logic [ENTRIES-1:0] load_v, clear_v, excl_v;
    logic               free_found, any_match;
    logic [IDX_W-1:0]   free_idx, first_idx;
    logic               wr_do, excl_do;

    assign full    = &valid_v;
    assign wr_do   = wr_req && !full && !inv_all && !inv_req;
    assign excl_do = excl_req && !inv_all && !inv_req && !wr_do;

    // Slot picker: the lowest invalid entry takes the next write.
    addr_cam_first #(.N(ENTRIES)) u_free (
        .req   (~valid_v),
        .found (free_found),
        .idx   (free_idx)
    );

    // Match priority: the lowest matching entry is reported.
    addr_cam_first #(.N(ENTRIES)) u_match (
        .req   (match_v),
        .found (any_match),
        .idx   (first_idx)
    );

    genvar g;
    generate
        for (g = 0; g < ENTRIES; g++) begin : g_ent
            assign clear_v[g] = inv_all || (inv_req && inv_idx == IDX_W'(g));
            assign load_v[g]  = wr_do && free_found && free_idx == IDX_W'(g);
            assign excl_v[g]  = excl_do && excl_idx == IDX_W'(g);

            addr_cam_entry #(.ADDR_W(ADDR_W), .ATTR_W(ATTR_W)) u_ent (
                .clk       (clk),
                .rst_n     (rst_n),
                .clear     (clear_v[g]),
                .load      (load_v[g]),
                .excl_we   (excl_v[g]),
                .excl_val  (excl_val),
                .wr_key    (wr_key),
                .wr_mask   (wr_mask),
                .wr_attr   (wr_attr),
                .srch_key  (srch_key),
                .srch_host (srch_host),
                .valid     (valid_v[g]),
                .match     (match_v[g]),
                .src       (src_v[g]),
                .exact     (exact_v[g])
            );
        end
    endgenerate

    // Result register: capture on a search request, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit       <= 1'b0;
            hit_idx   <= '0;
            multi     <= 1'b0;
            hit_src   <= 1'b0;
            hit_exact <= 1'b0;
        end else if (srch_req) begin
            hit       <= any_match;
            hit_idx   <= first_idx;
            multi     <= (match_v & (match_v - 1'b1)) != '0;
            hit_src   <= any_match && src_v[first_idx];
            hit_exact <= any_match && exact_v[first_idx];
        end
    end
endmodule

// File: rtl/addr_cam_chk.sv
// Module: assertion checker for addr_cam, attached by bind.
module addr_cam_chk #(
    parameter int IDX_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_req,
    input logic             inv_req,
    input logic             inv_all,
    input logic             srch_req,
    input logic             hit,
    input logic [IDX_W-1:0] hit_idx,
    input logic             multi,
    input logic             hit_src,
    input logic             hit_exact,
    input logic             full
);
    AST_MULTI_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        multi |-> hit); // R4
    AST_MISS_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (hit_idx == '0 && !multi && !hit_src && !hit_exact)); // R3
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !srch_req |=> ($stable(hit) && $stable(hit_idx) && $stable(multi))); // R9
    AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_req && !inv_req && !inv_all) |=> full); // R7
    AST_INV_ALL_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> !full); // R8
endmodule

bind addr_cam addr_cam_chk #(.IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_req    (wr_req),
    .inv_req   (inv_req),
    .inv_all   (inv_all),
    .srch_req  (srch_req),
    .hit       (hit),
    .hit_idx   (hit_idx),
    .multi     (multi),
    .hit_src   (hit_src),
    .hit_exact (hit_exact),
    .full      (full)
);

// File: tb/addr_cam_bench.sv
// Bench: a table of searches followed by directed corner cases.
module addr_cam_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_req, inv_req, inv_all, excl_req, excl_val, srch_req, srch_host;
    logic [47:0] wr_key, wr_mask, srch_key;
    logic [5:0]  wr_attr;
    logic [4:0]  inv_idx, excl_idx, hit_idx;
    logic        hit, multi, hit_src, hit_exact, full;
    int          checks = 0;
    int          errors = 0;

    always #2 clk = ~clk;

    addr_cam u_addr_cam (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_key(wr_key),
        .wr_mask(wr_mask), .wr_attr(wr_attr), .inv_req(inv_req),
        .inv_idx(inv_idx), .inv_all(inv_all), .excl_req(excl_req),
        .excl_idx(excl_idx), .excl_val(excl_val), .srch_req(srch_req),
        .srch_key(srch_key), .srch_host(srch_host), .hit(hit),
        .hit_idx(hit_idx), .multi(multi), .hit_src(hit_src),
        .hit_exact(hit_exact), .full(full)
    );

    // {host, key, hit, idx, multi, src, exact}
    localparam logic [57:0] VEC [5] = '{
        {1'b0, 48'h0180C2000000, 1'b1, 5'd0, 1'b1, 1'b0, 1'b1},
        {1'b0, 48'h0180C20000FF, 1'b1, 5'd1, 1'b0, 1'b1, 1'b0},
        {1'b0, 48'h123456789ABC, 1'b1, 5'd2, 1'b0, 1'b1, 1'b1},
        {1'b0, 48'h000000000000, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0},
        {1'b1, 48'h0180C2000000, 1'b1, 5'd0, 1'b1, 1'b0, 1'b1}
    };

    task automatic chk(input string tag, input logic [47:0] got, input logic [47:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic do_write(input logic [47:0] k, input logic [47:0] m, input logic [5:0] a);
        wr_req = 1'b1; wr_key = k; wr_mask = m; wr_attr = a;
        @(negedge clk);
        wr_req = 1'b0;
    endtask

    task automatic do_search(input logic host, input logic [47:0] k);
        srch_req = 1'b1; srch_host = host; srch_key = k;
        @(negedge clk);
        srch_req = 1'b0;
    endtask

    task automatic expect_res(input string tag, input logic eh, input logic [4:0] ei,
                              input logic em, input logic es, input logic ee);
        chk({tag, " hit"}, 48'(hit), 48'(eh));
        chk({tag, " idx"}, 48'(hit_idx), 48'(ei));
        chk({tag, " multi"}, 48'(multi), 48'(em));
        chk({tag, " src"}, 48'(hit_src), 48'(es));
        chk({tag, " exact"}, 48'(hit_exact), 48'(ee));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; wr_req = 0; inv_req = 0; inv_all = 0; excl_req = 0;
        excl_val = 0; srch_req = 0; srch_host = 0; wr_key = '0; wr_mask = '0;
        srch_key = '0; wr_attr = '0; inv_idx = '0; excl_idx = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state
        chk("R10 full", 48'(full), 48'd0);
        expect_res("R10", 0, 0, 0, 0, 0);

        // R6: load three entries into slots 0..2
        do_write(48'h0180C2000000, 48'hFFFFFFFFFFFF, 6'b000101);
        do_write(48'h0180C2000000, 48'hFFFFFFFFFF00, 6'b000011);
        do_write(48'h123456789ABC, 48'hFFFFFFFFFFFF, 6'b110110);

        // R1 R2 R3 R4 R9: table of searches
        for (int i = 0; i < 5; i++) begin
            do_search(VEC[i][57], VEC[i][56:9]);
            expect_res($sformatf("R1/R3/R4 vec%0d", i), VEC[i][8], VEC[i][7:3],
                       VEC[i][2], VEC[i][1], VEC[i][0]);
        end
        // R9: result held while no search is issued
        srch_key = 48'h0180C20000FF;
        @(negedge clk);
        expect_res("R9 hold", 1, 0, 1, 0, 1);

        // R5: hide entry 0 from host searches
        excl_req = 1; excl_idx = 5'd0; excl_val = 1;
        @(negedge clk); excl_req = 0;
        do_search(1'b1, 48'h0180C2000000);
        expect_res("R5 host skip", 1, 1, 0, 1, 0);
        do_search(1'b0, 48'h0180C2000000);
        expect_res("R5 rx ignores", 1, 0, 1, 0, 1);
        excl_req = 1; excl_val = 0;
        @(negedge clk); excl_req = 0;
        do_search(1'b1, 48'h0180C2000000);
        expect_res("R5 cleared", 1, 0, 1, 0, 1);

        // R8: single invalidate of entry 0
        inv_req = 1; inv_idx = 5'd0;
        @(negedge clk); inv_req = 0;
        do_search(1'b0, 48'h0180C2000000);
        expect_res("R8 inv one", 1, 1, 0, 1, 0);

        // R6: freed slot 0 is reused
        do_write(48'hAAAAAAAAAAAA, 48'hFFFFFFFFFFFF, 6'b000000);
        do_search(1'b0, 48'hAAAAAAAAAAAA);
        expect_res("R6 reuse", 1, 0, 0, 0, 0);

        // R7: fill slots 3..31
        for (int i = 3; i < 32; i++) begin
            if (i == 31) chk("R7 not full", 48'(full), 48'd0);
            do_write(48'h100 + 48'(i), 48'hFFFFFFFFFFFF, 6'b000001);
        end
        chk("R7 full", 48'(full), 48'd1);
        do_search(1'b0, 48'h100 + 48'd31);
        expect_res("R6 last slot", 1, 31, 0, 0, 0);
        do_write(48'hBEEF00000000, 48'hFFFFFFFFFFFF, 6'b000001);
        do_search(1'b0, 48'hBEEF00000000);
        expect_res("R7 write dropped", 0, 0, 0, 0, 0);

        // R8: invalidate all
        inv_all = 1;
        @(negedge clk); inv_all = 0;
        chk("R8 inv all full", 48'(full), 48'd0);
        do_search(1'b0, 48'h123456789ABC);
        expect_res("R8 inv all", 0, 0, 0, 0, 0);
        do_search(1'b0, 48'h100 + 48'd20);
        expect_res("R2 none valid", 0, 0, 0, 0, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule